// File: doc/BRIEF.md
# Mixed-Sign Multiplier Slice

This block is a pipelined multiplier slice that can work as four narrow multipliers, two medium multipliers, or one wide multiplier. The shape is chosen by a mode input. With the default narrow width of 9 bits, the shapes are four 9x9 lanes, two 18x18 lanes, or one 36x36 product. Two control bits set how the operands are read. One control applies to every A operand in the slice and the other applies to every B operand; each marks its operands as signed (two's complement) or unsigned. Every product keeps full precision: its width is the sum of the two operand widths.

The A input registers have two loading modes. They can be loaded in parallel from the data bus. In the narrow and medium shapes they can also be switched into a shift chain: the first lane takes a scan input, each later lane takes the previous lane's value, and the last lane drives a scan output. B always loads in parallel. In the wide shape a shift request is ignored.

The inputs are registered, and so is the product. A clock enable freezes both stages. A synchronous reset clears both stages.

Top module: `mulslice_top`

## Requirements
- R1: `mode_i` selects the shape. With NW the narrow width: `00` gives four NWxNW lanes, where lane k multiplies A[k*NW +: NW] by B[k*NW +: NW] into product[k*2NW +: 2NW]. `01` gives two 2NWx2NW lanes, where lane k uses A[k*2NW +: 2NW] and B[k*2NW +: 2NW] and writes product[k*4NW +: 4NW]. `10` and `11` both give one 4NWx4NW product over the whole bus.
- R2: `signa_i`=1 reads every A operand as two's complement, and 0 reads it as unsigned. `signb_i` does the same for B. When both are held at 0, every lane multiplies unsigned.
- R3: A lane's product is the exact, full-width result. It is unsigned when both operands are unsigned, and two's complement when either operand is signed.
- R4: The single pair of sign controls applies to all lanes in the same cycle.
- R5: The wide product equals a direct 4NWx4NW multiplication for all four sign combinations, including the most negative operand values.
- R6: Inputs are captured on an enabled clock edge. The product of those inputs appears on `product_o` after the next enabled edge, which is a latency of two clocks.
- R7: In shape `00` with `shift_i`=1, each enabled edge loads A lane 0 from `scan_i[NW-1:0]` and lane k from lane k-1. `scan_o` shows lane 3 zero-extended. B still loads in parallel.
- R8: In shape `01` with `shift_i`=1, each enabled edge loads A lane 0 from `scan_i` and lane 1 from lane 0. `scan_o` shows lane 1.
- R9: In shapes `10` and `11`, `shift_i` has no effect: A loads in parallel, and `scan_o` shows the upper 2NW bits of the A register.
- R10: While `ce_i`=0, every register holds, so `product_o` and `scan_o` do not change.
- R11: `rst_i` high at a clock edge clears all registers, whatever `ce_i` is. `product_o` and `scan_o` then read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| ce_i | input | 1 | Clock enable for all registers |
| mode_i | input | 2 | Shape select: 00 narrow, 01 medium, 1x wide |
| signa_i | input | 1 | 1 = A operands signed |
| signb_i | input | 1 | 1 = B operands signed |
| shift_i | input | 1 | 1 = A registers form a shift chain (narrow and medium shapes) |
| a_i | input | 4*NW | A operand bus |
| b_i | input | 4*NW | B operand bus |
| scan_i | input | 2*NW | Shift chain input |
| scan_o | output | 2*NW | Shift chain output (last A lane) |
| product_o | output | 8*NW | Registered product bus |

## Verification
Some behaviour is checked by assertions on every cycle:
- the movement of the shift chain in the narrow and medium shapes;
- the parallel load in the wide shape while a shift is requested;
- the freeze of all state while the enable is low;
- the clearing of the outputs after reset;
- the sign of each multiplier's result, which must follow the operand signs.

Other behaviour can only be shown by the bench's scenarios. The bench sweeps the narrow and medium shapes exhaustively at a reduced width, under all four sign settings. It exercises the wide shape with corner operands and a spread of other values. Scripted sequences show the two-clock latency and the values seen at `scan_o` and in the products after shifting.

// File: rtl/mulslice_pkg.sv
package mulslice_pkg;

    typedef enum logic [1:0] {
        MODE_N9   = 2'b00,
        MODE_N18  = 2'b01,
        MODE_W36  = 2'b10,
        MODE_W36B = 2'b11
    } mode_e;

    function automatic logic mode_is_wide(input logic [1:0] m);
        return m[1];
    endfunction

endpackage

// File: rtl/mulslice_mixmul.sv
module mulslice_mixmul #(
    parameter int AW = 9,
    parameter int BW = 9
) (
    input  logic [AW-1:0]    a_i,
    input  logic [BW-1:0]    b_i,
    input  logic             sa_i,
    input  logic             sb_i,
    output logic [AW+BW-1:0] p_o
);
    localparam int PW = AW + BW;

    logic [PW-1:0] ax;
    logic [PW-1:0] bx;
    logic          neg_a;
    logic          neg_b;

    // Each operand is extended by its sign bit only when marked signed.
    // The low PW bits of the modular product are then the exact result.
    always_comb begin
        neg_a = sa_i & a_i[AW-1];
        neg_b = sb_i & b_i[BW-1];
        ax    = {{BW{neg_a}}, a_i};
        bx    = {{AW{neg_b}}, b_i};
        p_o   = ax * bx;
        // R3: a signed result carries the sign implied by its operands
        if ((sa_i || sb_i) && (a_i != '0) && (b_i != '0)) begin
            a_r3_product_sign: assert (p_o[PW-1] == (neg_a ^ neg_b))
                else $error("R3 product sign mismatch");
        end
    end

endmodule

// File: rtl/mulslice_inreg.sv
module mulslice_inreg #(
    parameter int NW = 9
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              ce_i,
    input  logic              shift_i,
    input  logic [1:0]        mode_i,
    input  logic              signa_i,
    input  logic              signb_i,
    input  logic [4*NW-1:0]   a_i,
    input  logic [4*NW-1:0]   b_i,
    input  logic [2*NW-1:0]   scan_i,
    output logic [4*NW-1:0]   a_o,
    output logic [4*NW-1:0]   b_o,
    output logic              sa_o,
    output logic              sb_o,
    output logic [1:0]        mode_o,
    output logic [2*NW-1:0]   scan_o
);
    import mulslice_pkg::*;

    localparam int MW = 2 * NW;
    localparam int WW = 4 * NW;

    typedef struct packed {
        logic [WW-1:0] a;
        logic [WW-1:0] b;
        logic          sa;
        logic          sb;
        logic [1:0]    mode;
    } in_t;

    in_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ce_i) begin
            st_d.b    = b_i;
            st_d.sa   = signa_i;
            st_d.sb   = signb_i;
            st_d.mode = mode_i;
            if (shift_i && !mode_is_wide(mode_i)) begin
                if (mode_e'(mode_i) == MODE_N9) begin
                    st_d.a = {st_q.a[WW-NW-1:0], scan_i[NW-1:0]};
                end else begin
                    st_d.a = {st_q.a[WW-MW-1:0], scan_i};
                end
            end else begin
                st_d.a = a_i;
            end
        end
        if (rst_i) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign a_o    = st_q.a;
    assign b_o    = st_q.b;
    assign sa_o   = st_q.sa;
    assign sb_o   = st_q.sb;
    assign mode_o = st_q.mode;
    assign scan_o = (mode_e'(st_q.mode) == MODE_N9)
                  ? {{NW{1'b0}}, st_q.a[WW-1 -: NW]}
                  : st_q.a[WW-1 -: MW];

    // R7: narrow chain moves one lane per enabled edge
    a_r7_chain_narrow: assert property (@(posedge clk_i) disable iff (rst_i)
        (ce_i && shift_i && mode_i == 2'b00)
        |=> (st_q.a[NW-1:0] == $past(scan_i[NW-1:0]))
         && (st_q.a[WW-1:NW] == $past(st_q.a[WW-NW-1:0])))
        else $error("R7 narrow chain");

    // R8: medium chain moves one lane per enabled edge
    a_r8_chain_medium: assert property (@(posedge clk_i) disable iff (rst_i)
        (ce_i && shift_i && mode_i == 2'b01)
        |=> (st_q.a[MW-1:0] == $past(scan_i))
         && (st_q.a[WW-1:MW] == $past(st_q.a[MW-1:0])))
        else $error("R8 medium chain");

    // R9: wide shape always loads A in parallel
    a_r9_wide_parallel: assert property (@(posedge clk_i) disable iff (rst_i)
        (ce_i && mode_i[1]) |=> (st_q.a == $past(a_i)))
        else $error("R9 wide load");

    // R10: nothing moves while the enable is low
    a_r10_hold_inputs: assert property (@(posedge clk_i) disable iff (rst_i)
        !ce_i |=> $stable(st_q))
        else $error("R10 input hold");

endmodule

// File: rtl/mulslice_core.sv
module mulslice_core #(
    parameter int NW = 9
) (
    input  logic [4*NW-1:0] a_i,
    input  logic [4*NW-1:0] b_i,
    input  logic            sa_i,
    input  logic            sb_i,
    input  logic [1:0]      mode_i,
    output logic [8*NW-1:0] prod_o
);
    import mulslice_pkg::*;

    localparam int MW     = 2 * NW;
    localparam int WW     = 4 * NW;
    localparam int PW     = 8 * NW;
    localparam int LANES9 = 4;

    // Narrow lanes
    logic [PW-1:0] p9;

    for (genvar k = 0; k < LANES9; k++) begin : g_n9
        mulslice_mixmul #(.AW(NW), .BW(NW)) u_n9 (
            .a_i  (a_i[k*NW +: NW]),
            .b_i  (b_i[k*NW +: NW]),
            .sa_i (sa_i),
            .sb_i (sb_i),
            .p_o  (p9[k*MW +: MW])
        );
    end

    // Four medium multipliers: two serve the medium lanes, all four the wide product
    logic            wide;
    logic            sa_ll, sb_ll;
    logic [WW-1:0]   p_ll, p_hh, p_hl, p_lh;

    assign wide  = mode_is_wide(mode_i);
    assign sa_ll = wide ? 1'b0 : sa_i;
    assign sb_ll = wide ? 1'b0 : sb_i;

    mulslice_mixmul #(.AW(MW), .BW(MW)) u_ll (
        .a_i (a_i[MW-1:0]), .b_i (b_i[MW-1:0]),
        .sa_i(sa_ll),       .sb_i(sb_ll),       .p_o(p_ll));

    mulslice_mixmul #(.AW(MW), .BW(MW)) u_hh (
        .a_i (a_i[WW-1:MW]), .b_i (b_i[WW-1:MW]),
        .sa_i(sa_i),         .sb_i(sb_i),        .p_o(p_hh));

    mulslice_mixmul #(.AW(MW), .BW(MW)) u_hl (
        .a_i (a_i[WW-1:MW]), .b_i (b_i[MW-1:0]),
        .sa_i(sa_i),         .sb_i(1'b0),        .p_o(p_hl));

    mulslice_mixmul #(.AW(MW), .BW(MW)) u_lh (
        .a_i (a_i[MW-1:0]),  .b_i (b_i[WW-1:MW]),
        .sa_i(1'b0),         .sb_i(sb_i),        .p_o(p_lh));

    // Wide assembly: each partial is extended per its own signedness
    logic [PW-1:0] ll_x, hl_x, lh_x, hh_x, wide_sum;

    always_comb begin
        ll_x     = {{WW{1'b0}}, p_ll};
        hl_x     = {{WW{sa_i & p_hl[WW-1]}}, p_hl};
        lh_x     = {{WW{sb_i & p_lh[WW-1]}}, p_lh};
        hh_x     = {p_hh, {WW{1'b0}}};
        wide_sum = ll_x + (hl_x << MW) + (lh_x << MW) + hh_x;
    end

    always_comb begin
        case (mode_e'(mode_i))
            MODE_N9:  prod_o = p9;
            MODE_N18: prod_o = {p_hh, p_ll};
            default:  prod_o = wide_sum;
        endcase
    end

endmodule

// File: rtl/mulslice_top.sv
module mulslice_top #(
    parameter int NW = 9
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              ce_i,
    input  logic [1:0]        mode_i,
    input  logic              signa_i,
    input  logic              signb_i,
    input  logic              shift_i,
    input  logic [4*NW-1:0]   a_i,
    input  logic [4*NW-1:0]   b_i,
    input  logic [2*NW-1:0]   scan_i,
    output logic [2*NW-1:0]   scan_o,
    output logic [8*NW-1:0]   product_o
);
    localparam int WW = 4 * NW;
    localparam int PW = 8 * NW;

    logic [WW-1:0] a_q, b_q;
    logic          sa_q, sb_q;
    logic [1:0]    mode_q;
    logic [PW-1:0] core_p;

    mulslice_inreg #(.NW(NW)) u_inreg (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .ce_i    (ce_i),
        .shift_i (shift_i),
        .mode_i  (mode_i),
        .signa_i (signa_i),
        .signb_i (signb_i),
        .a_i     (a_i),
        .b_i     (b_i),
        .scan_i  (scan_i),
        .a_o     (a_q),
        .b_o     (b_q),
        .sa_o    (sa_q),
        .sb_o    (sb_q),
        .mode_o  (mode_q),
        .scan_o  (scan_o)
    );

    mulslice_core #(.NW(NW)) u_core (
        .a_i    (a_q),
        .b_i    (b_q),
        .sa_i   (sa_q),
        .sb_i   (sb_q),
        .mode_i (mode_q),
        .prod_o (core_p)
    );

    typedef struct packed {
        logic [PW-1:0] prod;
    } out_t;

    out_t out_d, out_q;

    always_comb begin
        out_d = out_q;
        if (ce_i) begin
            out_d.prod = core_p;
        end
        if (rst_i) begin
            out_d = '0;
        end
    end

    always_ff @(posedge clk_i) begin
        out_q <= out_d;
    end

    assign product_o = out_q.prod;

    // R11: reset clears what the ports show
    a_r11_reset_clears: assert property (@(posedge clk_i)
        rst_i |=> (product_o == '0) && (scan_o == '0))
        else $error("R11 reset clear");

    // R10: product frozen while the enable is low
    a_r10_hold_product: assert property (@(posedge clk_i) disable iff (rst_i)
        !ce_i |=> $stable(product_o))
        else $error("R10 product hold");

endmodule

// File: tb/mulslice_top_tb.sv
module mulslice_top_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NW = 3;
    localparam int MW = 2 * NW;
    localparam int AW = 4 * NW;
    localparam int PW = 8 * NW;

    logic          clk = 1'b0;
    logic          rst_i = 1'b1, ce_i = 1'b0, shift_i = 1'b0;
    logic          signa_i = 1'b0, signb_i = 1'b0;
    logic [1:0]    mode_i = 2'b00;
    logic [AW-1:0] a_i = '0, b_i = '0;
    logic [MW-1:0] scan_i = '0;
    logic [MW-1:0] scan_o;
    logic [PW-1:0] product_o;

    mulslice_top #(.NW(NW)) u_dut (
        .clk_i(clk), .rst_i(rst_i), .ce_i(ce_i), .mode_i(mode_i),
        .signa_i(signa_i), .signb_i(signb_i), .shift_i(shift_i),
        .a_i(a_i), .b_i(b_i), .scan_i(scan_i),
        .scan_o(scan_o), .product_o(product_o));

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    function automatic longint ext(input longint v, input int w, input bit s);
        longint r = v & ((longint'(1) << w) - 1);
        if (s && r[w-1]) r = r - (longint'(1) << w);
        return r;
    endfunction

    function automatic longint mulw(input longint a, input longint b, input int w,
                                    input bit sa, input bit sb);
        longint p = ext(a, w, sa) * ext(b, w, sb);
        return p & ((longint'(1) << (2*w)) - 1);
    endfunction

    function automatic logic [PW-1:0] expect_bus(input logic [AW-1:0] a, input logic [AW-1:0] b,
                                                 input bit sa, input bit sb, input logic [1:0] md);
        logic [PW-1:0] r = '0;
        longint p;
        if (md == 2'b00) begin
            for (int k = 0; k < 4; k++) begin
                p = mulw(longint'(a[k*NW +: NW]), longint'(b[k*NW +: NW]), NW, sa, sb);
                r[k*MW +: MW] = MW'(p);
            end
        end else if (md == 2'b01) begin
            for (int k = 0; k < 2; k++) begin
                p = mulw(longint'(a[k*MW +: MW]), longint'(b[k*MW +: MW]), MW, sa, sb);
                r[k*AW +: AW] = AW'(p);
            end
        end else begin
            p = mulw(longint'(a), longint'(b), AW, sa, sb);
            r = PW'(p);
        end
        return r;
    endfunction

    task automatic check(input string tag, input logic [PW-1:0] act, input logic [PW-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // streaming pipeline of expected results (two stages deep)
    bit            p1_v = 0, p2_v = 0;
    logic [PW-1:0] p1_e = '0, p2_e = '0;
    string         p1_t = "", p2_t = "";

    task automatic drive(input logic [AW-1:0] a, input logic [AW-1:0] b, input bit sa,
                         input bit sb, input logic [1:0] md, input bit v, input string tag);
        @(negedge clk);
        if (p2_v) check(p2_t, product_o, p2_e);
        p2_v = p1_v; p2_e = p1_e; p2_t = p1_t;
        p1_v = v; p1_e = expect_bus(a, b, sa, sb, md); p1_t = tag;
        ce_i = 1'b1; shift_i = 1'b0;
        a_i = a; b_i = b; signa_i = sa; signb_i = sb; mode_i = md;
    endtask

    task automatic flush();
        drive('0, '0, 1'b0, 1'b0, 2'b00, 1'b0, "");
        drive('0, '0, 1'b0, 1'b0, 2'b00, 1'b0, "");
        drive('0, '0, 1'b0, 1'b0, 2'b00, 1'b0, "");
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL R6 watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [AW-1:0] a, b;
        logic [PW-1:0] held_p;
        logic [MW-1:0] held_s;
        logic [NW-1:0] s9 [5];
        logic [MW-1:0] t18 [3];
        logic [AW-1:0] corner [4];
        s9     = '{3'd5, 3'd2, 3'd7, 3'd1, 3'd6};
        t18    = '{6'h2b, 6'h11, 6'h3e};
        corner = '{12'h000, 12'h7ff, 12'h800, 12'hfff};

        // R11: reset state
        repeat (3) @(negedge clk);
        check("R11 reset product", product_o, '0);
        check("R11 reset scan", PW'(scan_o), '0);
        rst_i = 1'b0;

        // R6: two-clock latency
        mode_i = 2'b10; a_i = 12'h123; b_i = 12'h456; ce_i = 1'b1;
        @(negedge clk);
        check("R6 not yet after one edge", product_o, '0);
        @(negedge clk);
        check("R6 product after two edges", product_o, PW'(24'h123 * 24'h456));

        // R10: hold with enable low
        held_p = product_o; held_s = scan_o;
        ce_i = 1'b0; a_i = 12'hfff; b_i = 12'h801; mode_i = 2'b00; shift_i = 1'b1;
        signa_i = 1'b1; scan_i = 6'h3f;
        repeat (3) @(negedge clk);
        check("R10 product held", product_o, held_p);
        check("R10 scan held", PW'(scan_o), PW'(held_s));

        // R11: reset while running
        rst_i = 1'b1; ce_i = 1'b1;
        @(negedge clk);
        check("R11 mid-run product", product_o, '0);
        check("R11 mid-run scan", PW'(scan_o), '0);
        rst_i = 1'b0;

        // R7: narrow shift chain
        mode_i = 2'b00; shift_i = 1'b1; signa_i = 1'b0; signb_i = 1'b0;
        b_i = {3'd5, 3'd4, 3'd3, 3'd2}; a_i = 12'habc;
        for (int j = 0; j < 5; j++) begin
            scan_i = {3'b101, s9[j]};
            @(negedge clk);
            if (j == 3) check("R7 scan_o after four shifts", PW'(scan_o), PW'(s9[0]));
        end
        check("R7 scan_o after five shifts", PW'(scan_o), PW'(s9[1]));
        check("R7 products from shifted lanes", product_o,
              expect_bus({s9[0], s9[1], s9[2], s9[3]}, {3'd5, 3'd4, 3'd3, 3'd2}, 0, 0, 2'b00));

        // R8: medium shift chain
        mode_i = 2'b01; signa_i = 1'b1; signb_i = 1'b0; b_i = {6'h3f, 6'h07};
        for (int j = 0; j < 3; j++) begin
            scan_i = t18[j];
            @(negedge clk);
            if (j == 1) check("R8 scan_o after two shifts", PW'(scan_o), PW'(t18[0]));
        end
        check("R8 scan_o after three shifts", PW'(scan_o), PW'(t18[1]));
        check("R8 products from shifted lanes", product_o,
              expect_bus({t18[0], t18[1]}, {6'h3f, 6'h07}, 1, 0, 2'b01));

        // R9: shift ignored in wide shape
        mode_i = 2'b10; shift_i = 1'b1; scan_i = 6'h2a;
        a_i = 12'ha5c; b_i = 12'h3f1; signa_i = 1'b1; signb_i = 1'b1;
        @(negedge clk);
        check("R9 scan_o shows upper A", PW'(scan_o), PW'(6'h29));
        @(negedge clk);
        check("R9 parallel product", product_o, expect_bus(12'ha5c, 12'h3f1, 1, 1, 2'b10));
        shift_i = 1'b0;

        // R1 R2 R3 R4: narrow shape, every pair in every lane, all sign settings
        for (int s = 0; s < 4; s++) begin
            for (int i = 0; i < 64; i++) begin
                for (int k = 0; k < 4; k++) begin
                    a[k*NW +: NW] = NW'(i) ^ NW'(k);
                    b[k*NW +: NW] = NW'(i >> 3) + NW'(k);
                end
                drive(a, b, s[0], s[1], 2'b00, 1'b1, "R1 R2 R4 narrow lanes");
            end
        end
        flush();

        // R1 R3: medium shape exhaustive
        for (int s = 0; s < 4; s++) begin
            for (int i = 0; i < 4096; i++) begin
                a = {~MW'(i), MW'(i)};
                b = {MW'(i >> 6) ^ 6'h15, MW'(i >> 6)};
                drive(a, b, s[0], s[1], 2'b01, 1'b1, "R1 R3 medium lanes");
            end
        end
        flush();

        // R5: wide shape, corners then spread values, both wide encodings
        for (int s = 0; s < 4; s++) begin
            for (int i = 0; i < 2048; i++) begin
                if (i < 16) begin
                    a = corner[i % 4]; b = corner[i / 4];
                end else begin
                    a = AW'(i * 2731 + 97);
                    b = AW'(i * 1597 + s * 311);
                end
                drive(a, b, s[0], s[1], {1'b1, 1'(i)}, 1'b1, "R5 wide product");
            end
        end
        flush();

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule